// File: doc/BRIEF.md
# Timed Sample Playback for Synthesizer Control Words

This block plays a stored sequence of 32-bit samples into the control inputs of a direct digital synthesizer. Samples are loaded into a 1024-word memory through a plain write port. A trigger then starts a run that reads every word from a programmed first address up to and including a programmed last address. A programmable timer paces the reads.

Each sample goes to one synthesizer parameter, chosen by configuration: the 32-bit frequency word, the 16-bit phase word or the 14-bit amplitude word. A fourth setting splits each sample into a phase part and a magnitude part, which are delivered together. Every output word has its own one-cycle strobe, and a completion flag shows that the last sample has been delivered. Output words that a sample does not target keep their previous values.

Top module: `mod_playback`

## Requirements
- R1: The sample store holds 1024 words of 32 bits. Any address from 0 to 1023 can be written through the write port, one word per cycle when `wr_en` is high, and read back by playback.
- R2: A trigger sampled at clock edge E0 sets the read address to `cfg_first`. The first sample's strobe is high in the cycle after edge E0+2. Sample k (counted from 0) has its strobe high after edge E0+2+k*(`cfg_gap`+1).
- R3: With `cfg_dest` = 2'b00, `freq_word` takes the whole 32-bit sample, and only `freq_vld` pulses.
- R4: With `cfg_dest` = 2'b01, `phase_word` takes sample bits 31:16, and only `phase_vld` pulses.
- R5: With `cfg_dest` = 2'b10, `amp_word` takes sample bits 31:18, and only `amp_vld` pulses.
- R6: With `cfg_dest` = 2'b11 (polar), `phase_word` takes bits 31:16 and `amp_word` takes bits 15:2. `phase_vld` and `amp_vld` pulse in the same cycle.
- R7: Output words change only in a cycle where their own strobe is high, and every output holds its value after the run ends.
- R8: `done` rises in the same cycle as the strobe of the sample read from `cfg_last`. It then stays high until the next trigger, and that trigger clears it at its own edge.
- R9: `cfg_first`, `cfg_last`, `cfg_gap` and `cfg_dest` are captured at the trigger edge. Changing them during a run has no effect on that run.
- R10: A trigger during a run restarts playback from the new first address. A read that was still in flight from the old run produces no strobe.
- R11: While `rst_n` is low, all output words are zero and all strobes and `done` are low.
- R12: When `cfg_first` equals `cfg_last`, exactly one sample is delivered, and `done` rises with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one word into the sample store |
| wr_addr | input | 10 | Store address to write |
| wr_data | input | 32 | Sample word to write |
| cfg_first | input | 10 | First address of a run |
| cfg_last | input | 10 | Last address of a run (not below cfg_first) |
| cfg_gap | input | 16 | Idle cycles between reads; spacing is cfg_gap+1 |
| cfg_dest | input | 2 | 00 frequency, 01 phase, 10 amplitude, 11 polar |
| trigger | input | 1 | Start (or restart) a run |
| freq_word | output | 32 | Frequency control word |
| freq_vld | output | 1 | New frequency word this cycle |
| phase_word | output | 16 | Phase control word |
| phase_vld | output | 1 | New phase word this cycle |
| amp_word | output | 14 | Amplitude control word |
| amp_vld | output | 1 | New amplitude word this cycle |
| done | output | 1 | Last sample of the run has been delivered |

## Verification
The bench checks the pacing at both extremes. It runs back-to-back reads with a gap of zero and long gaps of hundreds of cycles. A timer off by one would slip every later strobe by a cycle per sample. It runs a one-word sequence and a run ending at address 1023, where a sequencer with a wrong end compare would either skip the only sample or wrap around and keep playing. It retriggers in the middle of a run and changes the configuration after a trigger. A design that did not flush the read in flight would emit a stale strobe from the old run, and one that read the configuration live would change its slicing or its end point part way through the run.

// File: rtl/mp_pkg.sv
package mp_pkg;
  localparam int WORD_W  = 32;
  localparam int PHASE_W = 16;
  localparam int AMP_W   = 14;

  typedef enum logic [1:0] {
    DEST_FREQ  = 2'b00,
    DEST_PHASE = 2'b01,
    DEST_AMP   = 2'b10,
    DEST_POLAR = 2'b11
  } mp_dest_e;
endpackage

// File: rtl/mp_seq.sv
module mp_seq
  import mp_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int GAP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trigger,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic [GAP_W-1:0]  gap,
  input  mp_dest_e          dest,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_last,
  output mp_dest_e          dest_q
);
  logic              run_q, run_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] end_q, end_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic [GAP_W-1:0]  cnt_q, cnt_d;
  mp_dest_e          dest_d;
  logic              fire;
  logic              upd;

  assign fire    = run_q && (cnt_q == '0);
  assign rd_en   = fire;
  assign rd_addr = addr_q;
  assign rd_last = fire && (addr_q == end_q);
  assign upd     = trigger || run_q;

  always_comb begin
    run_d  = run_q;
    addr_d = addr_q;
    end_d  = end_q;
    gap_d  = gap_q;
    cnt_d  = cnt_q;
    dest_d = dest_q;
    if (trigger) begin
      run_d  = 1'b1;
      addr_d = first_addr;
      end_d  = last_addr;
      gap_d  = gap;
      dest_d = dest;
      cnt_d  = '0;
    end else if (fire) begin
      cnt_d = gap_q;
      if (addr_q == end_q) run_d = 1'b0;
      else                 addr_d = addr_q + 1'b1;
    end else if (run_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      addr_q <= '0;
      end_q  <= '0;
      gap_q  <= '0;
      cnt_q  <= '0;
      dest_q <= DEST_FREQ;
    end else if (upd) begin
      run_q  <= run_d;
      addr_q <= addr_d;
      end_q  <= end_d;
      gap_q  <= gap_d;
      cnt_q  <= cnt_d;
      dest_q <= dest_d;
    end
  end

  // R2
  first_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> rd_en);
endmodule

// File: rtl/mp_store.sv
module mp_store
  import mp_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_last,
  input  logic              flush,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_vld,
  output logic              rd_end
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic              vld_d, end_d;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

  always_comb begin
    vld_d = rd_en && !flush;
    end_d = rd_last && !flush;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld <= 1'b0;
      rd_end <= 1'b0;
    end else begin
      rd_vld <= vld_d;
      rd_end <= end_d;
    end
  end

  // R10
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !rd_vld);
endmodule

// File: rtl/mp_route.sv
module mp_route
  import mp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trigger,
  input  mp_dest_e           dest,
  input  logic [WORD_W-1:0]  rd_data,
  input  logic               rd_vld,
  input  logic               rd_end,
  output logic [WORD_W-1:0]  freq_word,
  output logic               freq_vld,
  output logic [PHASE_W-1:0] phase_word,
  output logic               phase_vld,
  output logic [AMP_W-1:0]   amp_word,
  output logic               amp_vld,
  output logic               done
);
  logic               take;
  logic               ld_f, ld_p, ld_a;
  logic [PHASE_W-1:0] phase_d;
  logic [AMP_W-1:0]   amp_d;
  logic               done_d;

  assign take = rd_vld && !trigger;

  always_comb begin
    ld_f    = 1'b0;
    ld_p    = 1'b0;
    ld_a    = 1'b0;
    phase_d = rd_data[WORD_W-1 -: PHASE_W];
    amp_d   = rd_data[WORD_W-1 -: AMP_W];
    unique case (dest)
      DEST_FREQ:  ld_f = take;
      DEST_PHASE: ld_p = take;
      DEST_AMP:   ld_a = take;
      DEST_POLAR: begin
        ld_p  = take;
        ld_a  = take;
        amp_d = rd_data[PHASE_W-1 -: AMP_W];
      end
      default: ;
    endcase
    if (trigger)                done_d = 1'b0;
    else if (rd_vld && rd_end)  done_d = 1'b1;
    else                        done_d = done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_vld  <= 1'b0;
      phase_vld <= 1'b0;
      amp_vld   <= 1'b0;
      done      <= 1'b0;
    end else begin
      freq_vld  <= ld_f;
      phase_vld <= ld_p;
      amp_vld   <= ld_a;
      done      <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    freq_word <= '0;
    else if (ld_f) freq_word <= rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase_word <= '0;
    else if (ld_p) phase_word <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    amp_word <= '0;
    else if (ld_a) amp_word <= amp_d;
  end

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !trigger) |=> done);

  // R3
  freq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freq_vld |-> (!phase_vld && !amp_vld));

  // R7
  freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_vld |-> $stable(freq_word));

  // R7
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_vld |-> $stable(phase_word));
endmodule

// File: rtl/mod_playback.sv
module mod_playback
  import mp_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int GAP_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [31:0]        wr_data,
  input  logic [ADDR_W-1:0]  cfg_first,
  input  logic [ADDR_W-1:0]  cfg_last,
  input  logic [GAP_W-1:0]   cfg_gap,
  input  logic [1:0]         cfg_dest,
  input  logic               trigger,
  output logic [31:0]        freq_word,
  output logic               freq_vld,
  output logic [15:0]        phase_word,
  output logic               phase_vld,
  output logic [13:0]        amp_word,
  output logic               amp_vld,
  output logic               done
);
  logic              rd_en, rd_last, rd_vld, rd_end;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_data;
  mp_dest_e          dest_q;

  mp_seq #(.ADDR_W(ADDR_W), .GAP_W(GAP_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .trigger    (trigger),
    .first_addr (cfg_first),
    .last_addr  (cfg_last),
    .gap        (cfg_gap),
    .dest       (mp_dest_e'(cfg_dest)),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_last    (rd_last),
    .dest_q     (dest_q)
  );

  mp_store #(.ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_last (rd_last),
    .flush   (trigger),
    .rd_data (rd_data),
    .rd_vld  (rd_vld),
    .rd_end  (rd_end)
  );

  mp_route u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .trigger    (trigger),
    .dest       (dest_q),
    .rd_data    (rd_data),
    .rd_vld     (rd_vld),
    .rd_end     (rd_end),
    .freq_word  (freq_word),
    .freq_vld   (freq_vld),
    .phase_word (phase_word),
    .phase_vld  (phase_vld),
    .amp_word   (amp_word),
    .amp_vld    (amp_vld),
    .done       (done)
  );
endmodule

// File: tb/mod_playback_bench.sv
module mod_playback_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [9:0]  wr_addr;
  logic [31:0] wr_data;
  logic [9:0]  cfg_first, cfg_last;
  logic [15:0] cfg_gap;
  logic [1:0]  cfg_dest;
  logic        trigger;
  logic [31:0] freq_word;
  logic [15:0] phase_word;
  logic [13:0] amp_word;
  logic        freq_vld, phase_vld, amp_vld, done;

  int compared = 0;
  int mismatched = 0;
  bit comparing = 0;
  string scen = "R11";

  mod_playback u_mod_playback (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_first(cfg_first), .cfg_last(cfg_last), .cfg_gap(cfg_gap), .cfg_dest(cfg_dest),
    .trigger(trigger), .freq_word(freq_word), .freq_vld(freq_vld),
    .phase_word(phase_word), .phase_vld(phase_vld), .amp_word(amp_word),
    .amp_vld(amp_vld), .done(done)
  );

  always #2.5 clk = ~clk;

  // behavioural reference: a timetable of scheduled deliveries
  logic [31:0] ref_mem [1024];
  logic [31:0] m_freq;
  logic [15:0] m_phase;
  logic [13:0] m_amp;
  logic        m_fv, m_pv, m_av, m_done;
  logic [1:0]  m_dest;
  longint      cyc = 0;
  longint      q_t[$];
  int          q_a[$];
  bit          q_l[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_freq = '0; m_phase = '0; m_amp = '0;
      m_fv = 0; m_pv = 0; m_av = 0; m_done = 0; m_dest = 2'b00;
      q_t.delete(); q_a.delete(); q_l.delete();
    end else begin
      cyc++;
      m_fv = 0; m_pv = 0; m_av = 0;
      if (trigger) begin
        q_t.delete(); q_a.delete(); q_l.delete();
        m_done = 0;
        m_dest = cfg_dest;
        for (int a = int'(cfg_first); a <= int'(cfg_last); a++) begin
          q_t.push_back(cyc + longint'(a - int'(cfg_first)) * (longint'(cfg_gap) + 1) + 2);
          q_a.push_back(a);
          q_l.push_back(a == int'(cfg_last));
        end
      end else if (q_t.size() > 0 && q_t[0] == cyc) begin
        logic [31:0] w;
        w = ref_mem[q_a[0]];
        case (m_dest)
          2'b00: begin m_freq = w; m_fv = 1; end
          2'b01: begin m_phase = w[31:16]; m_pv = 1; end
          2'b10: begin m_amp = w[31:18]; m_av = 1; end
          default: begin m_phase = w[31:16]; m_amp = w[15:2]; m_pv = 1; m_av = 1; end
        endcase
        if (q_l[0]) m_done = 1;
        void'(q_t.pop_front()); void'(q_a.pop_front()); void'(q_l.pop_front());
      end
      if (wr_en) ref_mem[wr_addr] = wr_data;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s (%s) %s: actual %h expected %h at cycle %0d", req, scen, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (comparing) begin
      chk("R3", "freq_word",  freq_word, m_freq);
      chk("R4", "phase_word", 32'(phase_word), 32'(m_phase));
      chk("R5", "amp_word",   32'(amp_word), 32'(m_amp));
      chk("R2", "strobes",    {29'b0, freq_vld, phase_vld, amp_vld}, {29'b0, m_fv, m_pv, m_av});
      chk("R8", "done",       32'(done), 32'(m_done));
    end
  end

  function automatic logic [31:0] gen(int i);
    return (32'(i) * 32'h9E3779B9) ^ {16'(i), 16'hA55A};
  endfunction

  task automatic fire(int first, int last, int gap, int dest);
    @(negedge clk);
    cfg_first = 10'(first); cfg_last = 10'(last);
    cfg_gap = 16'(gap); cfg_dest = 2'(dest);
    trigger = 1;
    @(negedge clk);
    trigger = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish, actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0;
    cfg_first = '0; cfg_last = '0; cfg_gap = '0; cfg_dest = '0; trigger = 0;
    repeat (4) @(negedge clk);
    // R11: reset state
    chk("R11", "freq_word reset", freq_word, 32'h0);
    chk("R11", "flags reset", {28'b0, freq_vld, phase_vld, amp_vld, done}, 32'h0);
    comparing = 1;
    @(negedge clk);
    rst_n = 1;

    // R1: load every address
    scen = "R1";
    for (int i = 0; i < 1024; i++) begin
      wr_en = 1; wr_addr = 10'(i); wr_data = gen(i);
      @(negedge clk);
    end
    wr_en = 0;

    scen = "R3"; fire(5, 9, 3, 0); wait_done();
    scen = "R4"; fire(100, 107, 0, 1); wait_done();
    scen = "R5"; fire(1020, 1023, 7, 2); wait_done();
    scen = "R6"; fire(0, 3, 2, 3); wait_done();

    // R12: one-word run, count strobes
    scen = "R12";
    begin
      int n = 0;
      fire(500, 500, 5, 0);
      for (int i = 0; i < 12; i++) begin
        if (freq_vld) n++;
        @(negedge clk);
      end
      chk("R12", "strobe count", 32'(n), 32'd1);
      chk("R12", "done after one", 32'(done), 32'd1);
    end

    // R9: change configuration during the run
    scen = "R9";
    fire(200, 210, 4, 1);
    cfg_first = 10'd7; cfg_last = 10'd8; cfg_gap = 16'd0; cfg_dest = 2'b00;
    wait_done();

    // R10: restart in the middle of a run (gap 1 leaves a read in flight)
    scen = "R10";
    fire(300, 320, 1, 3);
    repeat (6) @(negedge clk);
    fire(400, 402, 1, 2);
    wait_done();
    scen = "R10";
    fire(600, 640, 0, 0);
    repeat (10) @(negedge clk);
    fire(10, 12, 3, 1);
    wait_done();

    // R2: long gap and done hold (R7, R8)
    scen = "R2"; fire(1021, 1023, 700, 0); wait_done();
    scen = "R7"; repeat (30) @(negedge clk);

    comparing = 0;
    summary();
    $finish;
  end
endmodule